// File: doc/BRIEF.md
# Keyed watchdog timer controller

This block is a watchdog timer guarded against runaway software. It sits on a small byte-wide register bus carrying an address, write data, a write strobe, a read strobe and a flag that marks a single-bit manipulation access. Two registers live behind it. The first is a configuration register that may be set once after reset. It holds a stop control and a three-bit period select. The second is a restart register. Writing the one accepted key byte to it clears the running count.

Any access the block judges illegal raises a one-cycle reset request towards the system reset controller. The illegal cases are a second configuration write, a malformed configuration byte, a wrong key, and a bit-level access to the restart register. When the count runs out, the block raises the same request. Software that stops the watchdog with its single configuration write can touch the configuration register afterwards without penalty.

Top module: `wdt_keyed_ctrl`

## Requirements
- R1: After a synchronous reset, `rst_req` is low, the watchdog is running, and a read of the configuration register (address 0x1) returns 0x67. That value is fixed bits 7:5 = 011, stop bit 4 = 0, spare bit 3 = 0 and period select bits 2:0 = 7.
- R2: The first byte write to the configuration register with bits 7:5 equal to 011 and the bit-access flag low is accepted. The byte is stored and read back unchanged, the counter is cleared, and the register is locked.
- R3: A configuration write whose bits 7:5 are not 011, or that has the bit-access flag set, raises a reset request and leaves the register unchanged.
- R4: Any write to the configuration register after it has been locked (watchdog not stopped) raises a reset request and leaves the stored value unchanged.
- R5: An accepted configuration byte with bit 4 set stops the watchdog. No overflow then occurs, and every later configuration write of any kind is ignored without a reset request.
- R6: A byte write of 0xAC to the restart register (address 0x2) clears the count, so the next overflow comes one full period after that write. It raises no request.
- R7: A byte write of any value other than 0xAC to the restart register raises a reset request, whether or not the watchdog is stopped.
- R8: Any read or write of the restart register with the bit-access flag set raises a reset request.
- R9: A read of the restart register returns 0x9A.
- R10: While running, a reset request occurs every 2^(PRE_W+BASE_EXP+sel) clocks after the last clear (64 << sel with defaults). The count then restarts from zero.
- R11: A reset request is high for exactly the one cycle after the clock edge that sampled the offending access or the overflow. Coincident causes give a single pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_bit_op | input | 1 | Marks the access as a single-bit manipulation |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
Several properties are checked on every cycle. The lock bit and the stored configuration never change once set. A wrong key, a bit-level restart access or a relock attempt is followed by a request on the next cycle. Restart reads always return 0x9A. A cleared or stopped counter reads zero a cycle later. Only the bench's scenarios can show that the overflow falls on exactly the right clock for each period select, that a key write moves the next overflow, and that the stopped mode really stays quiet across thousands of cycles. Their reference model tracks elapsed clocks and is compared with the outputs each cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] KEY_VALUE    = 8'hAC;
    localparam logic [7:0] KEY_READBACK = 8'h9A;
    localparam logic [2:0] MODE_FIXED   = 3'b011;

    typedef struct packed {
        logic [2:0] fixed;
        logic       stop;
        logic       spare;
        logic [2:0] sel;
    } mode_t;

endpackage

// File: rtl/wdt_access_check.sv
module wdt_access_check
    import wdt_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h1,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'h2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_bit_op,
    input  logic              locked,
    input  logic              stopped,
    output logic              mode_load,
    output logic              key_clear,
    output logic              violation
);

    logic mode_hit;
    logic key_hit;

    always_comb begin
        mode_hit  = (bus_addr == MODE_ADDR);
        key_hit   = (bus_addr == KEY_ADDR);
        mode_load = 1'b0;
        key_clear = 1'b0;
        violation = 1'b0;

        // configuration register: write-once, byte access, fixed top bits
        if (bus_wr && mode_hit && !stopped) begin
            if (bus_bit_op || locked || (bus_wdata[7:5] != MODE_FIXED))
                violation = 1'b1;
            else
                mode_load = 1'b1;
        end

        // restart register: bit access of any kind is illegal, key must match
        if (key_hit && bus_bit_op && (bus_wr || bus_rd)) begin
            violation = 1'b1;
        end else if (key_hit && bus_wr) begin
            if (bus_wdata == KEY_VALUE)
                key_clear = 1'b1;
            else
                violation = 1'b1;
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int PRE_W    = 2,
    parameter int BASE_EXP = 4,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             overflow
);

    localparam int CNT_W = BASE_EXP + (2 ** SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [CNT_W-1:0] last_cnt;
    logic             tick;

    always_comb begin
        last_cnt = ~({CNT_W{1'b1}} << (BASE_EXP + int'(sel)));
        tick     = &s_q.pre;
        s_d      = s_q;
        overflow = 1'b0;
        if (!run || clear) begin
            s_d = '0;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
            if (tick) begin
                if (s_q.cnt == last_cnt) begin
                    s_d.cnt  = '0;
                    overflow = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: a clear leaves prescaler and count at zero
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q == '0));

    // R5: a halted counter stays at zero
    p_halt_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q == '0));

    // R10: the count never passes the selected terminal value
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= last_cnt);

endmodule

// File: rtl/wdt_keyed_ctrl.sv
module wdt_keyed_ctrl
    import wdt_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] MODE_ADDR   = 4'h1,
    parameter logic [ADDR_W-1:0] KEY_ADDR    = 4'h2,
    parameter int                PRE_W       = 2,
    parameter int                BASE_EXP    = 4,
    parameter logic [2:0]        DEFAULT_SEL = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_bit_op,
    output logic [7:0]        bus_rdata,
    output logic              rst_req
);

    localparam mode_t MODE_RESET = '{fixed: MODE_FIXED, stop: 1'b0,
                                     spare: 1'b0, sel: DEFAULT_SEL};

    typedef struct packed {
        mode_t mode;
        logic  locked;
        logic  req;
    } top_state_t;

    top_state_t st_d, st_q;
    logic mode_load;
    logic key_clear;
    logic violation;
    logic overflow;

    wdt_access_check #(
        .ADDR_W    (ADDR_W),
        .MODE_ADDR (MODE_ADDR),
        .KEY_ADDR  (KEY_ADDR)
    ) u_check (
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_bit_op (bus_bit_op),
        .locked     (st_q.locked),
        .stopped    (st_q.mode.stop),
        .mode_load  (mode_load),
        .key_clear  (key_clear),
        .violation  (violation)
    );

    wdt_tick_counter #(
        .PRE_W    (PRE_W),
        .BASE_EXP (BASE_EXP),
        .SEL_W    (3)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!st_q.mode.stop),
        .clear    (mode_load || key_clear),
        .sel      (st_q.mode.sel),
        .overflow (overflow)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = violation || overflow;
        if (mode_load) begin
            st_d.mode   = mode_t'(bus_wdata);
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_RESET;
            st_q.locked <= 1'b0;
            st_q.req    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (bus_addr == KEY_ADDR)       bus_rdata = KEY_READBACK;
            else if (bus_addr == MODE_ADDR) bus_rdata = st_q.mode;
        end
    end

    assign rst_req = st_q.req;

    // R2: once locked, the lock never drops before reset
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> st_q.locked);

    // R4: a locked configuration never changes
    p_mode_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.mode));

    // R4: relock attempt on a running watchdog is punished
    p_relock_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == MODE_ADDR && st_q.locked && !st_q.mode.stop) |=> rst_req);

    // R7: wrong key byte is punished
    p_bad_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == KEY_ADDR && bus_wdata != KEY_VALUE) |=> rst_req);

    // R8: bit-level access to the restart register is punished
    p_bitop_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_bit_op && bus_addr == KEY_ADDR) |=> rst_req);

    // R9: restart register reads back the fixed pattern
    p_key_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == KEY_ADDR) |-> (bus_rdata == KEY_READBACK));

endmodule

// File: tb/wdt_keyed_ctrl_bench.sv
`timescale 1ns/1ps
module wdt_keyed_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic       bit_op = 1'b0;
    logic [7:0] rdata;
    logic       rst_req;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R1";

    // reference model state
    int       m_clk;
    logic [7:0] m_mode;
    bit       m_locked, m_stop, m_req;
    int       m_sel;
    int       pulses;

    always #5 clk = ~clk;

    wdt_keyed_ctrl u_wdt_keyed_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_wr     (wr),
        .bus_rd     (rd),
        .bus_bit_op (bit_op),
        .bus_rdata  (rdata),
        .rst_req    (rst_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model: elapsed clocks since the last clear
    always @(posedge clk) begin
        bit viol, clr, ovf;
        if (!rst_n) begin
            m_mode = 8'h67; m_locked = 0; m_stop = 0; m_sel = 7; m_clk = 0; m_req = 0;
        end else begin
            viol = 0; clr = 0; ovf = 0;
            if (wr && addr == 4'h1 && !m_stop) begin
                if (bit_op || m_locked || wdata[7:5] != 3'b011) viol = 1;
                else begin
                    m_mode = wdata; m_locked = 1; m_stop = wdata[4];
                    m_sel = int'(wdata[2:0]); clr = 1;
                end
            end
            if (addr == 4'h2 && bit_op && (wr || rd)) viol = 1;
            else if (addr == 4'h2 && wr) begin
                if (wdata == 8'hAC) clr = 1; else viol = 1;
            end
            if (clr || m_stop) m_clk = 0;
            else begin
                m_clk++;
                if (m_clk == (1 << (6 + m_sel))) begin m_clk = 0; ovf = 1; end
            end
            m_req = viol || ovf;
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            check(cur_req, {7'd0, rst_req}, {7'd0, m_req});
            if (rst_req) pulses++;
            if (rd) begin
                if (addr == 4'h2)      check(cur_req, rdata, 8'h9A);
                else if (addr == 4'h1) check(cur_req, rdata, m_mode);
                else                   check(cur_req, rdata, 8'h00);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst_n = 0;
        idle(3); #2; rst_n = 1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input bit b);
        @(posedge clk); #2; addr = a; wdata = d; wr = 1; bit_op = b;
        @(posedge clk); #2; wr = 0; bit_op = 0; wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, input bit b);
        @(posedge clk); #2; addr = a; rd = 1; bit_op = b;
        @(posedge clk); #2; rd = 0; bit_op = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        do_reset();
        chk_en = 1;

        // R1: reset state and default configuration readback
        cur_req = "R1";
        idle(5);
        bus_read(4'h1, 0);
        check("R1", {7'd0, rst_req}, 8'h00);

        // R2 and R10: shortest period, several overflows
        cur_req = "R2";
        bus_write(4'h1, 8'h60, 0);
        bus_read(4'h1, 0);
        cur_req = "R10";
        pulses = 0;
        idle(200);
        check("R10", 8'(pulses), 8'd3);

        // R6: key writes move the next overflow
        cur_req = "R6";
        repeat (4) begin bus_write(4'h2, 8'hAC, 0); idle(40); end
        pulses = 0;
        idle(20);
        check("R6", 8'(pulses), 8'd0);
        idle(10);

        // R7: wrong key
        cur_req = "R7";
        bus_write(4'h2, 8'h55, 0);
        bus_write(4'h2, 8'h9A, 0);
        idle(3);

        // R8: bit-level access to restart register, write and read
        cur_req = "R8";
        bus_write(4'h2, 8'hAC, 1);
        idle(2);
        bus_read(4'h2, 1);
        idle(2);

        // R9: readback pattern
        cur_req = "R9";
        bus_read(4'h2, 0);

        // R4: second configuration write is refused
        cur_req = "R4";
        bus_write(4'h1, 8'h61, 0);
        bus_read(4'h1, 0);
        idle(5);

        // R11: back-to-back illegal accesses and overflow coincidence
        cur_req = "R11";
        idle(100);
        bus_write(4'h2, 8'h00, 0);
        idle(1);
        bus_write(4'h2, 8'h01, 0);
        idle(120);

        // R3: malformed and bit-level configuration writes
        do_reset();
        cur_req = "R3";
        bus_write(4'h1, 8'hE0, 0);
        bus_write(4'h1, 8'h41, 0);
        bus_write(4'h1, 8'h61, 1);
        bus_read(4'h1, 0);
        cur_req = "R2";
        bus_write(4'h1, 8'h62, 0);
        bus_read(4'h1, 0);
        cur_req = "R10";
        idle(600);

        // R5: stopped watchdog stays quiet and ignores configuration writes
        do_reset();
        cur_req = "R5";
        bus_write(4'h1, 8'h70, 0);
        pulses = 0;
        idle(300);
        bus_write(4'h1, 8'hFF, 0);
        bus_write(4'h1, 8'h60, 1);
        bus_read(4'h1, 0);
        idle(300);
        check("R5", 8'(pulses), 8'd0);
        cur_req = "R7";
        bus_write(4'h2, 8'h12, 0);
        idle(3);

        // R10: default period after reset without configuration
        do_reset();
        cur_req = "R10";
        pulses = 0;
        idle(8300);
        check("R10", 8'(pulses), 8'd1);

        finish_run();
    end

endmodule